// File: doc/BRIEF.md
# Signed-Magnitude Adder-Subtractor

This unit adds or subtracts two operands held in signed-magnitude form: a sign bit (1 means negative) and an unsigned magnitude of `MAG_W` bits. A single ripple adder does all the work. A conditional complementor sits in front of its B input, so the same adder either sums the magnitudes or forms A minus B. When it forms the difference, its end carry doubles as the magnitude comparison. A correction stage then re-complements the difference when B turned out larger, and it fixes the sign.

A caller presents both operands and the operation select, then raises `start` for one clock. On the following rising edge the unit registers the result sign, result magnitude, end carry and overflow flag, and it raises `done` for that single cycle. The registered outputs hold until the next start or a reset.

Top module: `sm_addsub_unit`

## Requirements
- R1: `op_sub` = 0 selects addition and 1 selects subtraction. An addition of operands with equal signs sums the magnitudes, and the result sign is the sign of A.
- R2: A subtraction of operands with unequal signs also sums the magnitudes, with the sign of A. An addition with equal signs and a subtraction with unequal signs both take this magnitude-sum path.
- R3: On the difference path (addition with unequal signs, or subtraction with equal signs), when A's magnitude is at least B's, the result magnitude is A minus B, the sign is that of A and `end_carry` is 1.
- R4: On the difference path, when B's magnitude exceeds A's, the result magnitude is B minus A, the sign is the inverse of A's sign and `end_carry` is 0.
- R5: Whenever the registered result magnitude is zero, the result sign is 0. This includes equal magnitudes on the difference path and a sum that wraps to zero.
- R6: `ovf` is 1 exactly when the sum path carries out of the top magnitude bit. The result magnitude is then the low `MAG_W` bits of the sum. On the difference path `ovf` is 0.
- R7: `end_carry` reports the carry out of the adder. On the sum path it is 1 when A+B reaches 2^MAG_W.
- R8: The outputs are captured on the rising edge at which `start` is sampled high. `done` is 1 only in the cycle after such an edge, so back-to-back starts give back-to-back results.
- R9: While `start` is low, operand and select changes have no effect: the result, `end_carry` and `ovf` hold, and `done` stays 0.
- R10: A rising edge with `rst_n` low clears the result, `end_carry`, `ovf` and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture request for the present operands |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of A, 1 = negative |
| a_mag | input | MAG_W | Magnitude of A |
| b_sign | input | 1 | Sign of B, 1 = negative |
| b_mag | input | MAG_W | Magnitude of B |
| res_sign | output | 1 | Registered result sign |
| res_mag | output | MAG_W | Registered result magnitude |
| end_carry | output | 1 | Registered adder end carry |
| ovf | output | 1 | Registered sum-path overflow flag |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The assertions assume that `start` is a known level at every edge after reset. They also assume that the operands and `op_sub` are known values whenever `start` is high, because their `$past` terms reuse the path decision taken from those inputs. The bench sets every input to a defined value before reset is released. It changes inputs only on falling edges and raises `start` for single cycles, or for a burst of consecutive cycles, with complete operands. After each start it also scrambles the operands while `start` is low, so the hold checks see input activity that must be ignored.

// File: rtl/sm_addsub_pkg.sv
// Shared type for the signed-magnitude adder-subtractor.
// Assumes nothing beyond being compiled first.
package sm_addsub_pkg;
    // Which adder path an operation takes.
    typedef enum logic {
        PATH_SUM  = 1'b0,  // magnitudes are added
        PATH_DIFF = 1'b1   // B is complemented, A minus B is formed
    } path_e;
endpackage

// File: rtl/sm_path_decode.sv
// Picks the adder path from the operation and the two operand signs.
// Assumes: op_sub = 1 requests subtraction; sign bit 1 means negative.
module sm_path_decode
    import sm_addsub_pkg::*;
(
    input  logic  op_sub,
    input  logic  a_sign,
    input  logic  b_sign,
    output path_e path
);
    // Difference path when the effective signs disagree.
    always_comb begin
        if (op_sub ^ a_sign ^ b_sign) path = PATH_DIFF;
        else                          path = PATH_SUM;
    end
endmodule

// File: rtl/sm_b_complementor.sv
// Conditionally inverts the B magnitude and supplies the matching carry-in,
// so that the adder forms A + ~B + 1 on the difference path.
// Assumes: the adder consumes carry_in as its bit-0 carry.
module sm_b_complementor
    import sm_addsub_pkg::*;
#(
    parameter int MAG_W = 8
) (
    input  path_e              path,
    input  logic [MAG_W-1:0]   b_mag,
    output logic [MAG_W-1:0]   b_eff,
    output logic               carry_in
);
    logic invert;

    // Inversion control derived from the path.
    always_comb invert = (path == PATH_DIFF);

    // One XOR per magnitude bit.
    for (genvar i = 0; i < MAG_W; i++) begin : g_bit
        assign b_eff[i] = b_mag[i] ^ invert;
    end

    // A set carry-in completes the two's complement.
    assign carry_in = invert;
endmodule

// File: rtl/sm_ripple_adder.sv
// Parallel adder built from a row of identical full-adder cells.
// Assumes: carry_out is the end carry, one bit above the sum.
module sm_ripple_adder #(
    parameter int MAG_W = 8
) (
    input  logic [MAG_W-1:0] op_a,
    input  logic [MAG_W-1:0] op_b,
    input  logic             carry_in,
    output logic [MAG_W-1:0] sum,
    output logic             carry_out
);
    localparam int CHAIN_W = MAG_W + 1;

    logic [CHAIN_W-1:0] carry;

    assign carry[0] = carry_in;

    // Each cell: sum is the 3-input XOR, carry is the majority.
    for (genvar i = 0; i < MAG_W; i++) begin : g_cell
        assign sum[i]       = op_a[i] ^ op_b[i] ^ carry[i];
        assign carry[i + 1] = (op_a[i] & op_b[i]) | (op_a[i] & carry[i]) |
                              (op_b[i] & carry[i]);
    end

    assign carry_out = carry[CHAIN_W-1];
endmodule

// File: rtl/sm_result_fix.sv
// Turns the raw adder output into a signed-magnitude result: re-complements
// the difference when B was larger, sets the sign, forces a zero result to
// sign 0, and flags sum-path overflow.
// Assumes: raw_sum and end_carry come from the same adder evaluation.
module sm_result_fix
    import sm_addsub_pkg::*;
#(
    parameter int MAG_W = 8
) (
    input  path_e            path,
    input  logic             a_sign,
    input  logic [MAG_W-1:0] raw_sum,
    input  logic             end_carry,
    output logic [MAG_W-1:0] fix_mag,
    output logic             fix_sign,
    output logic             fix_ovf
);
    localparam logic [MAG_W-1:0] ONE = {{(MAG_W-1){1'b0}}, 1'b1};

    logic [MAG_W-1:0] neg_sum;

    // Two's complement of the raw difference, used when B was larger.
    always_comb neg_sum = ~raw_sum + ONE;

    // Selects magnitude and sign by path and end carry, then clears -0.
    always_comb begin
        fix_mag  = raw_sum;
        fix_sign = a_sign;
        fix_ovf  = 1'b0;
        if (path == PATH_SUM) begin
            fix_ovf = end_carry;
        end else if (!end_carry) begin
            fix_mag  = neg_sum;
            fix_sign = ~a_sign;
        end
        if (fix_mag == '0) fix_sign = 1'b0;
    end
endmodule

// File: rtl/sm_addsub_unit.sv
// Top of the signed-magnitude adder-subtractor. Decodes the path,
// complements B when needed, adds, corrects, and registers the result with
// a one-cycle done pulse.
// Assumes: start is sampled on rising edges; operands are valid while start
// is high; rst_n is synchronous and active low.
module sm_addsub_unit
    import sm_addsub_pkg::*;
#(
    parameter int MAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_sub,
    input  logic             a_sign,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_sign,
    input  logic [MAG_W-1:0] b_mag,
    output logic             res_sign,
    output logic [MAG_W-1:0] res_mag,
    output logic             end_carry,
    output logic             ovf,
    output logic             done
);
    path_e            path_w;
    logic [MAG_W-1:0] b_eff_w;
    logic             cin_w;
    logic [MAG_W-1:0] sum_w;
    logic             cout_w;
    logic [MAG_W-1:0] fix_mag_w;
    logic             fix_sign_w;
    logic             fix_ovf_w;

    sm_path_decode u_decode (
        .op_sub (op_sub),
        .a_sign (a_sign),
        .b_sign (b_sign),
        .path   (path_w)
    );

    sm_b_complementor #(.MAG_W(MAG_W)) u_comp (
        .path     (path_w),
        .b_mag    (b_mag),
        .b_eff    (b_eff_w),
        .carry_in (cin_w)
    );

    sm_ripple_adder #(.MAG_W(MAG_W)) u_adder (
        .op_a      (a_mag),
        .op_b      (b_eff_w),
        .carry_in  (cin_w),
        .sum       (sum_w),
        .carry_out (cout_w)
    );

    sm_result_fix #(.MAG_W(MAG_W)) u_fix (
        .path      (path_w),
        .a_sign    (a_sign),
        .raw_sum   (sum_w),
        .end_carry (cout_w),
        .fix_mag   (fix_mag_w),
        .fix_sign  (fix_sign_w),
        .fix_ovf   (fix_ovf_w)
    );

    // Result capture on start; holds otherwise; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_sign  <= 1'b0;
            res_mag   <= '0;
            end_carry <= 1'b0;
            ovf       <= 1'b0;
        end else if (start) begin
            res_sign  <= fix_sign_w;
            res_mag   <= fix_mag_w;
            end_carry <= cout_w;
            ovf       <= fix_ovf_w;
        end
    end

    // Done pulse: one cycle per captured start.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= start;
    end

    // R8: a start always yields done on the next cycle.
    a_r8_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R9: without start, the outputs hold and done stays low.
    a_r9_hold_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!done && $stable(res_mag) && $stable(res_sign) &&
                    $stable(end_carry) && $stable(ovf)));

    // R5: never a negative zero.
    a_r5_no_negative_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_mag == '0) |-> !res_sign);

    // R6: overflow only from a sum-path end carry.
    a_r6_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ovf == ($past(path_w == PATH_SUM) && end_carry)));

    // R4: a difference with B larger is nonzero and takes the inverted sign.
    a_r4_b_larger_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !end_carry && $past(path_w == PATH_DIFF)) |->
        ((res_mag != '0) && (res_sign == !$past(a_sign))));

    // R3: a nonzero difference with A larger keeps the sign of A.
    a_r3_a_larger_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && end_carry && $past(path_w == PATH_DIFF) && (res_mag != '0)) |->
        (res_sign == $past(a_sign)));
endmodule

// File: tb/sm_addsub_unit_tb_top.sv
// Directed bench for sm_addsub_unit; one task per scenario.
module sm_addsub_unit_tb_top;
    localparam int W    = 8;
    localparam int FULL = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_sub = 1'b0;
    logic         a_sign = 1'b0;
    logic [W-1:0] a_mag = '0;
    logic         b_sign = 1'b0;
    logic [W-1:0] b_mag = '0;
    logic         res_sign;
    logic [W-1:0] res_mag;
    logic         end_carry;
    logic         ovf;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    sm_addsub_unit #(.MAG_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
        .res_sign(res_sign), .res_mag(res_mag), .end_carry(end_carry),
        .ovf(ovf), .done(done)
    );

    always #2 clk = ~clk;  // 4 ns period

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected outcome from the requirements.
    task automatic model(input bit sub, input bit as, input int am, input bit bs,
                         input int bm, output int s, output int m, output int e,
                         output int v);
        bit diff;
        diff = sub ^ as ^ bs;
        if (!diff) begin
            e = ((am + bm) >= FULL) ? 1 : 0;
            m = (am + bm) % FULL;
            s = as;
            v = e;
        end else begin
            e = (am >= bm) ? 1 : 0;
            m = e ? (am - bm) : (bm - am);
            s = e ? as : !as;
            v = 0;
        end
        if (m == 0) s = 0;
    endtask

    // One operation: start for one cycle, check result, then check hold.
    task automatic run_op(string req, bit sub, bit as, int am, bit bs, int bm);
        int s, m, e, v;
        model(sub, as, am, bs, bm, s, m, e, v);
        @(negedge clk);
        op_sub = sub; a_sign = as; a_mag = W'(am); b_sign = bs; b_mag = W'(bm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(req, "sign", res_sign, s);
        check(req, "mag", res_mag, m);
        check(req, "end_carry", end_carry, e);
        check(req, "ovf", ovf, v);
        check("R8", "done pulse", done, 1);
        a_mag = ~a_mag; b_mag = b_mag + 8'd37; op_sub = ~op_sub; b_sign = ~b_sign;
        @(negedge clk);
        check("R8", "done single cycle", done, 0);
        check("R9", "held mag", res_mag, m);
        check("R9", "held sign", res_sign, s);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", "mag", res_mag, 0);
        check("R10", "sign", res_sign, 0);
        check("R10", "end_carry", end_carry, 0);
        check("R10", "ovf", ovf, 0);
        check("R10", "done", done, 0);
        rst_n = 1'b1;
    endtask

    task automatic test_hold_long();
        // R9: several idle cycles with shifting inputs.
        run_op("R4", 1'b1, 1'b0, 9, 1'b0, 40);
        for (int k = 0; k < 4; k++) begin
            a_mag = W'(k * 61); b_mag = W'(k * 13); a_sign = k[0];
            @(negedge clk);
            check("R9", "idle done", done, 0);
            check("R9", "idle mag", res_mag, 31);
            check("R9", "idle sign", res_sign, 1);
            check("R9", "idle end_carry", end_carry, 0);
        end
    endtask

    task automatic test_back_to_back();
        // R8: two consecutive starts, each result in its own cycle.
        @(negedge clk);
        op_sub = 1'b0; a_sign = 1'b0; a_mag = 8'd10; b_sign = 1'b0; b_mag = 8'd5;
        start = 1'b1;
        @(negedge clk);
        check("R8", "first done", done, 1);
        check("R8", "first mag", res_mag, 15);
        op_sub = 1'b1; a_mag = 8'd3; b_mag = 8'd50;
        @(negedge clk);
        start = 1'b0;
        check("R8", "second done", done, 1);
        check("R8", "second mag", res_mag, 47);
        check("R8", "second sign", res_sign, 1);
        @(negedge clk);
        check("R8", "done drops", done, 0);
    endtask

    task automatic test_reset_clears_result();
        // R10: reset after a nonzero result clears it.
        run_op("R6", 1'b0, 1'b1, 200, 1'b1, 100);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "mag cleared", res_mag, 0);
        check("R10", "sign cleared", res_sign, 0);
        check("R10", "ovf cleared", ovf, 0);
        check("R10", "end_carry cleared", end_carry, 0);
        rst_n = 1'b1;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        test_reset();
        run_op("R1", 1'b0, 1'b0, 29, 1'b0, 14);   // +43
        run_op("R1", 1'b0, 1'b1, 14, 1'b1, 7);    // -21
        run_op("R2", 1'b1, 1'b0, 20, 1'b1, 5);    // +25
        run_op("R2", 1'b1, 1'b1, 33, 1'b0, 11);   // -44
        run_op("R3", 1'b1, 1'b1, 14, 1'b1, 7);    // -7
        run_op("R3", 1'b0, 1'b0, 90, 1'b1, 1);    // +89
        run_op("R4", 1'b1, 1'b0, 14, 1'b0, 20);   // -6
        run_op("R4", 1'b0, 1'b1, 0, 1'b0, 255);   // +255
        run_op("R5", 1'b1, 1'b1, 14, 1'b1, 14);   // +0
        run_op("R5", 1'b0, 1'b0, 0, 1'b1, 0);     // +0 with B zero
        run_op("R5", 1'b0, 1'b1, 128, 1'b1, 128); // wraps to 0, sign 0
        run_op("R6", 1'b0, 1'b0, 200, 1'b0, 100); // 44 with overflow
        run_op("R6", 1'b1, 1'b1, 255, 1'b0, 255); // 254, negative, overflow
        run_op("R7", 1'b0, 1'b0, 128, 1'b0, 127); // 255, no carry
        run_op("R7", 1'b1, 1'b0, 77, 1'b0, 76);   // carry on difference
        test_hold_long();
        test_back_to_back();
        test_reset_clears_result();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule